// File: doc/BRIEF.md
# No-turnaround synchronous SRAM model

A synthesizable, cycle-accurate model of a small synchronous static RAM whose reads and writes have the same latency, so a bus can carry read, write, read traffic with no idle cycle between them. Address and control are captured on every rising clock edge. Write data is not taken with the command. It arrives late, at the edge where a read issued in the same slot would return its data. Two fixed timings are offered. In pipelined timing the read output is registered and write data lags the command by two edges. In flow-through timing the read output comes straight from the array and write data lags the command by one edge.

An access is started by a load cycle that carries an address. Continue cycles then step a two-bit burst counter in linear or interleaved order without a new address. Per-byte write enables allow partial writes. Three chip selects allow depth expansion. A clock-enable input stalls the whole block. An asynchronous output enable gates the read bus. A sleep input parks the block while keeping its contents. The read bus is a separate output with a drive flag, not a bidirectional port. The array is a parameterised register memory that is cleared at reset.

Top module: `zt_sram`

## Requirements
- R1: At an edge where clk_en_n is low and the block is awake, adv_ld low with cs_a_n low, cs_b high and cs_c_n low starts an access at addr. wr_n high makes it a read and wr_n low makes it a write. If adv_ld is low and any chip select is false, the cycle is a deselect and nothing is read, written or driven.
- R2: In pipelined timing (pipe_mode high), a read issued at an edge drives its data after the next effective edge. A write issued at an edge takes wdata at the second effective edge after it. Read and write commands may follow each other on consecutive edges.
- R3: In flow-through timing (pipe_mode low), a read drives its data after the edge that issues it. A write takes wdata at the next effective edge.
- R4: Byte enables are active low. be_n[i] low writes wdata bits [9i+8:9i] into byte i of the word. A write with every be_n bit high is an abort: it changes no memory and never drives the bus.
- R5: adv_ld high makes a continue cycle. It repeats the type of the running burst (read or write) at the next burst address and ignores the chip selects and wr_n. A continue cycle after a deselect stays deselected. be_n is sampled again on every write continue cycle.
- R6: A load sets the burst start to addr[1:0] and the step to 0, and each continue cycle adds 1 to the step modulo 4. The word address is addr[AW-1:2] joined with the start plus the step modulo 4 when burst_il is low, or the start XOR the step when burst_il is high. The fifth access of a burst is at the start address again.
- R7: With clk_en_n high at an edge, no state changes: not the pipeline, the burst counter, the memory or the output register. A pipelined read output already on the bus stays driven with the same data.
- R8: rdata_drv is high only when a read result is due and oe_n is low. oe_n acts asynchronously, with no clock edge. Write and abort cycles never drive the bus.
- R9: sleep high at an edge puts the block to sleep after the following edge, and sleep low wakes it after the following edge in the same way. While asleep, every input except sleep and reset is ignored, rdata_drv is low and memory contents are kept.
- R10: In pipelined timing, a read of a word whose write takes its data at the same edge returns the new bytes where that write's byte enables are active, and the old bytes elsewhere.
- R11: After reset, no access is pending, rdata_drv is low, the burst state is deselected and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the block |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | Low: load a new address; high: continue the burst |
| wr_n | input | 1 | Low: write, high: read (load cycles only) |
| be_n | input | NB | Byte write enables, active low |
| addr | input | AW | Word address |
| wdata | input | NB*BW | Late write data |
| pipe_mode | input | 1 | High: pipelined timing, low: flow-through timing |
| burst_il | input | 1 | High: interleaved burst order, low: linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rdata | output | NB*BW | Read data, zero when not driven |
| rdata_drv | output | 1 | Read data is being driven |

## Verification
A wrong burst counter or a misrouted stage shows up as a wrong word on the read bus after the very next read. A write committed one edge early or late shows up on the first read of that word, because the captured wdata changes every cycle. A broken stall or sleep freeze shows up as a drive flag that falls too early or too late, on the edge that should have been frozen. A missing forward path returns stale bytes on a read that follows its write by one edge. The reference model compares drive flag and data after every edge, so each of these shows at most one or two cycles after the faulty edge.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;

   typedef enum logic [1:0] {
      BS_IDLE  = 2'd0,
      BS_READ  = 2'd1,
      BS_WRITE = 2'd2
   } burst_e;

   // edges between a change of the sleep request and its effect
   localparam int SLEEP_LAT = 2;

   // low two address bits of burst access number `step`
   function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                                input logic [1:0] step,
                                                input logic       il);
      return il ? (start ^ step) : (start + step);
   endfunction

endpackage

// File: rtl/zt_sram_sleep.sv
`timescale 1ns/1ps
module zt_sram_sleep
   import zt_sram_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   output logic asleep
);
   logic [SLEEP_LAT-1:0] sync_q;

   generate
      for (genvar i = 0; i < SLEEP_LAT; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= sleep;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   assign asleep = sync_q[SLEEP_LAT-1];
endmodule

// File: rtl/zt_sram_cmd.sv
`timescale 1ns/1ps
module zt_sram_cmd
   import zt_sram_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          adv_ld,
   input  logic          cs_a_n,
   input  logic          cs_b,
   input  logic          cs_c_n,
   input  logic          wr_n,
   input  logic          burst_il,
   input  logic [AW-1:0] addr,
   output logic          acc_vld,
   output logic          acc_wr,
   output logic [AW-1:0] acc_addr
);
   localparam int BASE_W = AW - 2;

   burst_e            bst_q, bst_d;
   logic [BASE_W-1:0] base_q, base_d;
   logic [1:0]        start_q, start_d;
   logic [1:0]        step_q, step_d;
   logic              selected;

   assign selected = !cs_a_n && cs_b && !cs_c_n;

   always_comb begin
      bst_d   = bst_q;
      base_d  = base_q;
      start_d = start_q;
      step_d  = step_q + 2'd1;
      if (!adv_ld) begin
         base_d  = addr[AW-1:2];
         start_d = addr[1:0];
         step_d  = 2'd0;
         if (!selected)  bst_d = BS_IDLE;
         else if (wr_n)  bst_d = BS_READ;
         else            bst_d = BS_WRITE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bst_q   <= BS_IDLE;
         base_q  <= '0;
         start_q <= '0;
         step_q  <= '0;
      end else if (en) begin
         bst_q   <= bst_d;
         base_q  <= base_d;
         start_q <= start_d;
         step_q  <= step_d;
      end
   end

   assign acc_vld  = (bst_d != BS_IDLE);
   assign acc_wr   = (bst_d == BS_WRITE);
   assign acc_addr = {base_d, burst_offset(start_d, step_d, burst_il)};
endmodule

// File: rtl/zt_sram_pipe.sv
`timescale 1ns/1ps
module zt_sram_pipe #(
   parameter int AW = 6,
   parameter int NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          pipe_mode,
   input  logic          acc_vld,
   input  logic          acc_wr,
   input  logic [AW-1:0] acc_addr,
   input  logic [NB-1:0] acc_be,
   output logic          rd_vld,
   output logic [AW-1:0] rd_addr,
   output logic          cm_en,
   output logic [AW-1:0] cm_addr,
   output logic [NB-1:0] cm_be,
   output logic          fw_vld,
   output logic [AW-1:0] fw_addr,
   output logic [NB-1:0] fw_be
);
   localparam int NSTG = 2;

   typedef struct packed {
      logic          vld;
      logic          wr;
      logic [AW-1:0] addr;
      logic [NB-1:0] be;
   } stage_t;

   stage_t stg_q [NSTG];
   stage_t late;

   generate
      for (genvar s = 0; s < NSTG; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n)   stg_q[0] <= '0;
               else if (en)  stg_q[0] <= '{vld: acc_vld, wr: acc_wr,
                                           addr: acc_addr, be: acc_be};
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (!rst_n)   stg_q[s] <= '0;
               else if (en)  stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   // write whose data is taken at this edge
   assign late    = pipe_mode ? stg_q[NSTG-1] : stg_q[0];
   assign cm_en   = en && late.vld && late.wr && (|late.be);
   assign cm_addr = late.addr;
   assign cm_be   = late.be;

   assign rd_vld  = stg_q[0].vld && !stg_q[0].wr;
   assign rd_addr = stg_q[0].addr;

   assign fw_vld  = pipe_mode && stg_q[NSTG-1].vld && stg_q[NSTG-1].wr;
   assign fw_addr = stg_q[NSTG-1].addr;
   assign fw_be   = stg_q[NSTG-1].be;
endmodule

// File: rtl/zt_sram_array.sv
`timescale 1ns/1ps
module zt_sram_array #(
   parameter int AW = 6,
   parameter int NB = 2,
   parameter int BW = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [NB-1:0]    wbe,
   input  logic [NB*BW-1:0] wdat,
   input  logic [AW-1:0]    raddr,
   input  logic             fw_vld,
   input  logic [AW-1:0]    fw_addr,
   input  logic [NB-1:0]    fw_be,
   output logic [NB*BW-1:0] rdat
);
   localparam int DW    = NB * BW;
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] raw;
   logic          hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      end else if (we) begin
         for (int b = 0; b < NB; b++)
            if (wbe[b]) mem[waddr][b*BW +: BW] <= wdat[b*BW +: BW];
      end
   end

   assign raw = mem[raddr];
   assign hit = fw_vld && (fw_addr == raddr);

   generate
      for (genvar b = 0; b < NB; b++) begin : g_merge
         assign rdat[b*BW +: BW] = (hit && fw_be[b]) ? wdat[b*BW +: BW]
                                                     : raw[b*BW +: BW];
      end
   endgenerate
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram #(
   parameter int AW = 6,
   parameter int NB = 2,
   parameter int BW = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_en_n,
   input  logic             cs_a_n,
   input  logic             cs_b,
   input  logic             cs_c_n,
   input  logic             adv_ld,
   input  logic             wr_n,
   input  logic [NB-1:0]    be_n,
   input  logic [AW-1:0]    addr,
   input  logic [NB*BW-1:0] wdata,
   input  logic             pipe_mode,
   input  logic             burst_il,
   input  logic             oe_n,
   input  logic             sleep,
   output logic [NB*BW-1:0] rdata,
   output logic             rdata_drv
);
   localparam int DW = NB * BW;

   generate
      if (AW < 3) begin : g_bad_aw
         $error("zt_sram: AW must be at least 3");
      end
      if (NB < 1) begin : g_bad_nb
         $error("zt_sram: NB must be at least 1");
      end
      if (BW < 1) begin : g_bad_bw
         $error("zt_sram: BW must be at least 1");
      end
   endgenerate

   logic          asleep, en;
   logic          acc_vld, acc_wr;
   logic [AW-1:0] acc_addr;
   logic          rd_vld;
   logic [AW-1:0] rd_addr;
   logic          cm_en, fw_vld;
   logic [AW-1:0] cm_addr, fw_addr;
   logic [NB-1:0] cm_be, fw_be;
   logic [DW-1:0] rd_fwd;
   logic          out_vld_q;
   logic [DW-1:0] out_data_q;
   logic          due_vld;
   logic [DW-1:0] due_data;

   assign en = !clk_en_n && !asleep;

   zt_sram_sleep u_sleep (
      .clk    (clk),
      .rst_n  (rst_n),
      .sleep  (sleep),
      .asleep (asleep)
   );

   zt_sram_cmd #(.AW(AW)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .adv_ld   (adv_ld),
      .cs_a_n   (cs_a_n),
      .cs_b     (cs_b),
      .cs_c_n   (cs_c_n),
      .wr_n     (wr_n),
      .burst_il (burst_il),
      .addr     (addr),
      .acc_vld  (acc_vld),
      .acc_wr   (acc_wr),
      .acc_addr (acc_addr)
   );

   zt_sram_pipe #(.AW(AW), .NB(NB)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .pipe_mode (pipe_mode),
      .acc_vld   (acc_vld),
      .acc_wr    (acc_wr),
      .acc_addr  (acc_addr),
      .acc_be    (~be_n),
      .rd_vld    (rd_vld),
      .rd_addr   (rd_addr),
      .cm_en     (cm_en),
      .cm_addr   (cm_addr),
      .cm_be     (cm_be),
      .fw_vld    (fw_vld),
      .fw_addr   (fw_addr),
      .fw_be     (fw_be)
   );

   zt_sram_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cm_en),
      .waddr   (cm_addr),
      .wbe     (cm_be),
      .wdat    (wdata),
      .raddr   (rd_addr),
      .fw_vld  (fw_vld),
      .fw_addr (fw_addr),
      .fw_be   (fw_be),
      .rdat    (rd_fwd)
   );

   // registered read output for pipelined timing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld_q  <= 1'b0;
         out_data_q <= '0;
      end else if (en) begin
         out_vld_q  <= rd_vld;
         out_data_q <= rd_fwd;
      end
   end

   assign due_vld   = pipe_mode ? out_vld_q  : rd_vld;
   assign due_data  = pipe_mode ? out_data_q : rd_fwd;
   assign rdata_drv = due_vld && !oe_n && !asleep;
   assign rdata     = rdata_drv ? due_data : '0;
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
   parameter int DW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clk_en_n,
   input logic          oe_n,
   input logic          sleep,
   input logic          asleep,
   input logic          rdata_drv,
   input logic          out_vld_q,
   input logic [DW-1:0] out_data_q
);
   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !rdata_drv);                                    // R11

   AST_OE_BLOCKS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rdata_drv);                                            // R8

   AST_STALL_FREEZES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(out_vld_q) && $stable(out_data_q)));       // R7

   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ##1 asleep);                                           // R9

   AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep |=> ##1 !asleep);                                         // R9

   AST_ASLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !rdata_drv);                                          // R9
endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_en_n   (clk_en_n),
   .oe_n       (oe_n),
   .sleep      (sleep),
   .asleep     (asleep),
   .rdata_drv  (rdata_drv),
   .out_vld_q  (out_vld_q),
   .out_data_q (out_data_q)
);

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
   localparam int AW    = 6;
   localparam int NB    = 2;
   localparam int BW    = 9;
   localparam int DW    = NB * BW;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b0, cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
   logic          adv_ld = 1'b0, wr_n = 1'b1;
   logic [NB-1:0] be_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          pipe_mode = 1'b1, burst_il = 1'b0, oe_n = 1'b0, sleep = 1'b0;
   logic [DW-1:0] rdata;
   logic          rdata_drv;

   int    checks = 0;
   int    fails  = 0;
   bit    run    = 0;
   string phase  = "R11 reset";

   zt_sram #(.AW(AW), .NB(NB), .BW(BW)) dut_i (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n),
      .cs_b(cs_b), .cs_c_n(cs_c_n), .adv_ld(adv_ld), .wr_n(wr_n),
      .be_n(be_n), .addr(addr), .wdata(wdata), .pipe_mode(pipe_mode),
      .burst_il(burst_il), .oe_n(oe_n), .sleep(sleep),
      .rdata(rdata), .rdata_drv(rdata_drv)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s @%0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct {
      int            wa;
      logic [NB-1:0] be;
      int            due;
   } pw_t;

   logic [DW-1:0] m_mem [DEPTH];
   pw_t           wq[$];
   pw_t           keep[$];
   int            eff, bst, base, start, k, prd_a, ca;
   bit            m_s1, m_s2, prd_v, ev, rd_now, effe;
   logic [DW-1:0] ed;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_mem[i]) m_mem[i] = '0;
         wq.delete();
         eff = 0; bst = 0; base = 0; start = 0; k = 0;
         m_s1 = 0; m_s2 = 0; prd_v = 0; ev = 0; ed = '0;
      end else begin
         effe = !m_s2 && !clk_en_n;
         m_s2 = m_s1;
         m_s1 = sleep;
         if (effe) begin
            eff++;
            keep.delete();
            foreach (wq[i]) begin
               if (wq[i].due == eff) begin
                  for (int b = 0; b < NB; b++)
                     if (wq[i].be[b]) m_mem[wq[i].wa][b*BW +: BW] = wdata[b*BW +: BW];
               end else keep.push_back(wq[i]);
            end
            wq = keep;
            if (!adv_ld) begin
               if (!cs_a_n && cs_b && !cs_c_n) begin
                  bst = wr_n ? 1 : 2;
                  base = int'(addr) / 4; start = int'(addr) % 4; k = 0;
               end else bst = 0;
            end else k = (k + 1) % 4;
            ca = base * 4 + (burst_il ? (start ^ k) : ((start + k) % 4));
            rd_now = (bst == 1);
            if (bst == 2 && be_n != '1)
               wq.push_back('{wa: ca, be: ~be_n, due: eff + (pipe_mode ? 2 : 1)});
            if (pipe_mode) begin
               ev = prd_v;
               if (prd_v) ed = m_mem[prd_a];
               prd_v = rd_now; prd_a = ca;
            end else begin
               ev = rd_now;
               if (rd_now) ed = m_mem[ca];
               prd_v = 0;
            end
         end
      end
   end

   // compare every cycle, a quarter period after the rising edge
   always begin
      @(posedge clk);
      #5;
      if (rst_n && run) begin
         bit exp_drv;
         exp_drv = ev && !oe_n && !m_s2;
         chk(rdata_drv == exp_drv, {phase, " drive flag"},
             DW'(rdata_drv), DW'(exp_drv));
         if (exp_drv)
            chk(rdata == ed, {phase, " read data"}, rdata, ed);
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(input logic cen, input logic adv, input logic [2:0] cs,
                       input logic wn, input logic [NB-1:0] bn, input int a);
      clk_en_n = cen; adv_ld = adv; {cs_a_n, cs_b, cs_c_n} = cs;
      wr_n = wn; be_n = bn; addr = a[AW-1:0]; wdata = DW'($urandom);
      @(negedge clk);
   endtask

   task automatic rd(input int a);                step(0, 0, 3'b010, 1, '1, a); endtask
   task automatic wr(input int a, input logic [NB-1:0] bn); step(0, 0, 3'b010, 0, bn, a); endtask
   task automatic cont(input logic [NB-1:0] bn);  step(0, 1, 3'b101, $urandom % 2, bn, 0); endtask
   task automatic desel(input logic [2:0] cs);    step(0, 0, cs, 1, '1, 0); endtask
   task automatic stall();                        step(1, 0, 3'b010, 0, '0, 0); endtask
   task automatic flush();
      for (int i = 0; i < 4; i++) desel(3'b110);
   endtask

   task automatic directed();
      phase = "R2/R3 read-write-read";
      wr(4, 2'b00); rd(4); wr(5, 2'b00); rd(5); rd(4); wr(6, 2'b00); rd(6);
      desel(3'b110); rd(5); rd(6); desel(3'b110); desel(3'b110);
      phase = "R10 pending write forward";
      wr(8, 2'b00); rd(8); wr(9, 2'b10); rd(9); desel(3'b110); rd(9);
      desel(3'b110); desel(3'b110);
      phase = "R4 byte enables and abort";
      wr(12, 2'b11); rd(12); wr(13, 2'b01); wr(13, 2'b10); rd(13);
      desel(3'b110); rd(13); desel(3'b110); desel(3'b110);
      phase = "R5/R6 linear burst";
      burst_il = 1'b0;
      wr(17, 2'b00); cont(2'b00); cont(2'b11); cont(2'b00);
      rd(17); cont('1); cont('1); cont('1); cont('1); desel(3'b110);
      phase = "R6 interleaved burst";
      burst_il = 1'b1;
      wr(21, 2'b00); cont(2'b00); cont(2'b00); cont(2'b00);
      rd(22); cont('1); cont('1); cont('1); cont('1); desel(3'b110);
      burst_il = 1'b0;
      phase = "R1 chip selects and R5 continue after deselect";
      desel(3'b110); desel(3'b011); desel(3'b000); cont('1); cont(2'b00);
      step(0, 0, 3'b011, 0, 2'b00, 4); rd(4); desel(3'b110); desel(3'b110);
      phase = "R7 clock enable stall";
      rd(5); stall(); stall(); rd(4); wr(6, 2'b00); stall(); stall(); rd(6);
      stall(); desel(3'b110); desel(3'b110);
      phase = "R8 output enable";
      rd(4); rd(5);
      oe_n = 1'b1; #1;
      chk(rdata_drv == 1'b0, "R8 async output enable", DW'(rdata_drv), '0);
      oe_n = 1'b0; #1;
      desel(3'b110); desel(3'b110);
      phase = "R9 sleep";
      wr(30, 2'b00); sleep = 1'b1; rd(30); rd(4);
      for (int i = 0; i < 4; i++) wr(30, 2'b00);
      sleep = 1'b0; rd(30); rd(30); rd(30); rd(4); desel(3'b110); desel(3'b110);
   endtask

   task automatic random_traffic(input int n);
      for (int i = 0; i < n; i++) begin
         int sel;
         sel = $urandom % 10;
         oe_n  = ($urandom % 8 == 0);
         burst_il = (($urandom % 16) == 0) ? ~burst_il : burst_il;
         if ($urandom % 48 == 0) sleep = ~sleep;
         if (sel < 3)       rd($urandom % DEPTH);
         else if (sel < 6)  wr($urandom % DEPTH, NB'($urandom));
         else if (sel < 8)  cont(NB'($urandom));
         else if (sel == 8) stall();
         else               desel(3'($urandom));
      end
      sleep = 1'b0; oe_n = 1'b0;
      for (int i = 0; i < 3; i++) desel(3'b110);
      flush();
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      run   = 1'b1;
      @(posedge clk); #5;
      chk(rdata_drv == 1'b0, "R11 drive low after reset", DW'(rdata_drv), '0);
      chk(rdata == '0, "R11 bus zero after reset", rdata, '0);
      @(negedge clk);
      phase = "R11 reset contents";
      rd(40); rd(41); desel(3'b110); desel(3'b110);

      pipe_mode = 1'b1;
      directed();
      phase = "R2 pipelined random traffic";
      random_traffic(700);

      pipe_mode = 1'b0;
      flush();
      phase = "R3 flow-through directed";
      directed();
      phase = "R3 flow-through random traffic";
      random_traffic(700);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule